// File: doc/BRIEF.md
# Proportionate-Fair Task State Update Unit

This unit keeps the per-task bookkeeping that a proportionate-fair (Pfair) multiprocessor scheduler needs at every slot boundary. Each task entry holds an execution demand `e` and a period `p`. All quantities are multiplied by `p`, so the task's weight becomes the integer `e` and one slot of service is worth `p`. At each slot strobe every programmed entry updates at the same time. It adds `e` to its lag and subtracts `p` when the task ran in the slot just ended. It also advances its ideal progress and the floor of that progress. Only additions and comparisons are used.

From that state the unit derives a characteristic symbol for each task: plus, zero or minus. It then places each task in exactly one of three classes. A task is urgent when it must run. It is ahead when it must not run. Otherwise it is contending, and a later selection stage orders the contending tasks. Tasks are loaded through a valid/ready programming stream. The producer must hold `cfg_valid` and its payload until it sees `cfg_ready` high at a clock edge. `cfg_ready` drops during the slot strobe cycle, so a write never collides with an update.

Top module: `pfair_task_state`

## Requirements
- R1: A synchronous reset marks every entry unprogrammed and clears every accumulator. While an entry is unprogrammed, its three class outputs are 0 and its symbol is 00.
- R2: A write is taken at a clock edge where `cfg_valid` and `cfg_ready` are both 1. `cfg_ready` is 0 exactly in cycles where `slot_tick` is 1, and a write offered then is not taken. A taken write stores `e` (`cfg_exec`, with 1 ≤ e ≤ p) and `p` (`cfg_period`) into entry `cfg_idx`, marks the entry programmed and zeroes its lag and accumulators. An index of `NUM_TASKS` or more is ignored.
- R3: The symbol of task i sits at `task_sym[2i+1:2i]`. It encodes the sign of Ideal(t+1) − FloorIdeal(t) − p as 01 for plus, 00 for zero and 11 for minus. The code 10 never appears.
- R4: On a slot strobe, each programmed entry's lag becomes lag + e − p when `sched_last[i]` is 1, and lag + e when it is 0. Lag starts at 0.
- R5: On a slot strobe, Ideal gains `e`. FloorIdeal gains `p` when the old Ideal + e ≥ old FloorIdeal + p, and holds otherwise. Both start at 0.
- R6: A programmed task is urgent when its lag is greater than 0 and its symbol is not minus.
- R7: A programmed task is ahead when its lag is less than 0 and its symbol is not plus.
- R8: A programmed task that is neither urgent nor ahead is contending. At most one class output is 1 per task.
- R9: Without a strobe or a taken write, no output changes, whatever `sched_last` does.
- R10: All programmed entries update on the same strobe, each using its own `sched_last` bit.
- R11: Reprogramming one entry restarts only that entry. The other entries keep their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_tick | input | 1 | One-cycle slot boundary strobe |
| cfg_valid | input | 1 | Programming write offered |
| cfg_ready | output | 1 | Programming write can be taken |
| cfg_idx | input | IDX_W | Entry to program |
| cfg_exec | input | PERIOD_W | Execution demand e |
| cfg_period | input | PERIOD_W | Period p |
| sched_last | input | NUM_TASKS | Task ran in the slot just ended |
| task_urgent | output | NUM_TASKS | Urgent class per task |
| task_ahead | output | NUM_TASKS | Ahead class per task |
| task_contend | output | NUM_TASKS | Contending class per task |
| task_sym | output | 2*NUM_TASKS | Characteristic symbol per task |

## Verification
The bench runs three tasks of different weight: one third, two thirds and one. It steers their service bits by hand, so that a single trace walks each symbol code and drives one task into the urgent class and another into the ahead class. A long run feeds each entry a different pseudo-random service bit on every strobe. That run separates per-entry updates from shared ones and exposes any mistake in the floor-crossing comparison as the ideal accumulator wraps its residue. Idle cycles with changing service bits, a write offered in the strobe cycle, and a mid-run reprogram of one entry show that state moves only through the two permitted paths.

// File: rtl/pfair_pkg.sv
package pfair_pkg;
  typedef enum logic [1:0] {
    SYM_ZERO  = 2'b00,
    SYM_PLUS  = 2'b01,
    SYM_MINUS = 2'b11
  } sym_e;
endpackage

// File: rtl/pfair_cfg_decode.sv
module pfair_cfg_decode #(
  parameter int NUM_TASKS = 4,
  parameter int IDX_W     = 2
) (
  input  logic                 accept,
  input  logic [IDX_W-1:0]     idx,
  output logic [NUM_TASKS-1:0] load
);
  for (genvar i = 0; i < NUM_TASKS; i++) begin : g_dec
    assign load[i] = accept && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/pfair_task_cell.sv
// One task entry: programmed demand and period, signed lag, and the
// residue Ideal - FloorIdeal, which always lies in [0, p).
module pfair_task_cell #(
  parameter int PERIOD_W = 8,
  parameter int LAG_W    = PERIOD_W + 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tick,
  input  logic                       served,
  input  logic                       load,
  input  logic [PERIOD_W-1:0]        load_exec,
  input  logic [PERIOD_W-1:0]        load_period,
  output logic                       valid_o,
  output logic [PERIOD_W-1:0]        exec_o,
  output logic [PERIOD_W-1:0]        period_o,
  output logic [PERIOD_W-1:0]        resid_o,
  output logic signed [LAG_W-1:0]    lag_o
);
  localparam int EXT_W = LAG_W - PERIOD_W;

  logic                    valid_q;
  logic [PERIOD_W-1:0]     exec_q, period_q, resid_q;
  logic signed [LAG_W-1:0] lag_q;

  logic [PERIOD_W:0]       sum_w;
  logic                    crosses;
  logic signed [LAG_W-1:0] gain, cost;

  assign sum_w   = {1'b0, resid_q} + {1'b0, exec_q};
  assign crosses = sum_w >= {1'b0, period_q};
  assign gain    = $signed({{EXT_W{1'b0}}, exec_q});
  assign cost    = served ? $signed({{EXT_W{1'b0}}, period_q}) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      exec_q   <= '0;
      period_q <= '0;
      resid_q  <= '0;
      lag_q    <= '0;
    end else if (load) begin
      valid_q  <= 1'b1;
      exec_q   <= load_exec;
      period_q <= load_period;
      resid_q  <= '0;
      lag_q    <= '0;
    end else if (tick && valid_q) begin
      lag_q   <= lag_q + gain - cost;
      resid_q <= crosses ? (resid_q + exec_q - period_q) : (resid_q + exec_q);
    end
  end

  assign valid_o  = valid_q;
  assign exec_o   = exec_q;
  assign period_o = period_q;
  assign resid_o  = resid_q;
  assign lag_o    = lag_q;
endmodule

// File: rtl/pfair_task_class.sv
// Symbol and class derivation for one entry.
module pfair_task_class
  import pfair_pkg::*;
#(
  parameter int PERIOD_W = 8,
  parameter int LAG_W    = PERIOD_W + 2
) (
  input  logic                    valid,
  input  logic [PERIOD_W-1:0]     exec_v,
  input  logic [PERIOD_W-1:0]     period_v,
  input  logic [PERIOD_W-1:0]     resid,
  input  logic signed [LAG_W-1:0] lag,
  output sym_e                    sym,
  output logic                    urgent,
  output logic                    ahead,
  output logic                    contend
);
  logic [PERIOD_W:0] next_rel;
  logic              lag_pos, lag_neg;

  // Ideal(t+1) - FloorIdeal(t) - p == resid + e - p
  assign next_rel = {1'b0, resid} + {1'b0, exec_v};
  assign lag_neg  = lag[LAG_W-1];
  assign lag_pos  = !lag[LAG_W-1] && (lag != '0);

  always_comb begin
    if (!valid)                            sym = SYM_ZERO;
    else if (next_rel > {1'b0, period_v})  sym = SYM_PLUS;
    else if (next_rel == {1'b0, period_v}) sym = SYM_ZERO;
    else                                   sym = SYM_MINUS;
  end

  always_comb begin
    urgent  = valid && lag_pos && (sym != SYM_MINUS);
    ahead   = valid && lag_neg && (sym != SYM_PLUS);
    contend = valid && !urgent && !ahead;
  end
endmodule

// File: rtl/pfair_task_state.sv
module pfair_task_state
  import pfair_pkg::*;
#(
  parameter int NUM_TASKS = 4,
  parameter int PERIOD_W  = 8,
  localparam int IDX_W    = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1,
  localparam int LAG_W    = PERIOD_W + 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   slot_tick,
  input  logic                   cfg_valid,
  output logic                   cfg_ready,
  input  logic [IDX_W-1:0]       cfg_idx,
  input  logic [PERIOD_W-1:0]    cfg_exec,
  input  logic [PERIOD_W-1:0]    cfg_period,
  input  logic [NUM_TASKS-1:0]   sched_last,
  output logic [NUM_TASKS-1:0]   task_urgent,
  output logic [NUM_TASKS-1:0]   task_ahead,
  output logic [NUM_TASKS-1:0]   task_contend,
  output logic [2*NUM_TASKS-1:0] task_sym
);
  logic                 accept;
  logic [NUM_TASKS-1:0] load;

  assign cfg_ready = !slot_tick;
  assign accept    = cfg_valid && cfg_ready;

  pfair_cfg_decode #(.NUM_TASKS(NUM_TASKS), .IDX_W(IDX_W)) u_dec (
    .accept (accept),
    .idx    (cfg_idx),
    .load   (load)
  );

  for (genvar i = 0; i < NUM_TASKS; i++) begin : g_task
    logic                    valid;
    logic [PERIOD_W-1:0]     exec_v, period_v, resid;
    logic signed [LAG_W-1:0] lag;
    sym_e                    sym;

    pfair_task_cell #(.PERIOD_W(PERIOD_W), .LAG_W(LAG_W)) u_cell (
      .clk         (clk),
      .rst         (rst),
      .tick        (slot_tick),
      .served      (sched_last[i]),
      .load        (load[i]),
      .load_exec   (cfg_exec),
      .load_period (cfg_period),
      .valid_o     (valid),
      .exec_o      (exec_v),
      .period_o    (period_v),
      .resid_o     (resid),
      .lag_o       (lag)
    );

    pfair_task_class #(.PERIOD_W(PERIOD_W), .LAG_W(LAG_W)) u_class (
      .valid    (valid),
      .exec_v   (exec_v),
      .period_v (period_v),
      .resid    (resid),
      .lag      (lag),
      .sym      (sym),
      .urgent   (task_urgent[i]),
      .ahead    (task_ahead[i]),
      .contend  (task_contend[i])
    );

    assign task_sym[2*i+1:2*i] = sym;
  end
endmodule

// File: rtl/pfair_task_state_chk.sv
module pfair_task_state_chk #(
  parameter int NUM_TASKS = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   slot_tick,
  input logic                   cfg_valid,
  input logic                   cfg_ready,
  input logic [NUM_TASKS-1:0]   task_urgent,
  input logic [NUM_TASKS-1:0]   task_ahead,
  input logic [NUM_TASKS-1:0]   task_contend,
  input logic [2*NUM_TASKS-1:0] task_sym
);
  AST_READY_DROPS_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    slot_tick |-> !cfg_ready); // R2

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (task_urgent == '0 && task_ahead == '0 &&
                    task_contend == '0 && task_sym == '0)); // R1

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!slot_tick && !(cfg_valid && cfg_ready)) |=>
      ($stable(task_urgent) && $stable(task_ahead) &&
       $stable(task_contend) && $stable(task_sym))); // R9

  for (genvar i = 0; i < NUM_TASKS; i++) begin : g_chk
    AST_ONE_CLASS: assert property (@(posedge clk) disable iff (rst)
      $onehot0({task_urgent[i], task_ahead[i], task_contend[i]})); // R8

    AST_SYM_LEGAL: assert property (@(posedge clk) disable iff (rst)
      task_sym[2*i+1:2*i] != 2'b10); // R3
  end
endmodule

bind pfair_task_state pfair_task_state_chk #(.NUM_TASKS(NUM_TASKS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .slot_tick    (slot_tick),
  .cfg_valid    (cfg_valid),
  .cfg_ready    (cfg_ready),
  .task_urgent  (task_urgent),
  .task_ahead   (task_ahead),
  .task_contend (task_contend),
  .task_sym     (task_sym)
);

// File: tb/pfair_task_state_bench.sv
module pfair_task_state_bench;
  localparam int N  = 4;
  localparam int PW = 8;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          slot_tick = 1'b0;
  logic          cfg_valid = 1'b0;
  logic          cfg_ready;
  logic [IW-1:0] cfg_idx = '0;
  logic [PW-1:0] cfg_exec = '0;
  logic [PW-1:0] cfg_period = '0;
  logic [N-1:0]  sched_last = '0;
  logic [N-1:0]  task_urgent, task_ahead, task_contend;
  logic [2*N-1:0] task_sym;

  always #5 clk = ~clk;

  pfair_task_state #(.NUM_TASKS(N), .PERIOD_W(PW)) u_pfair_task_state (
    .clk, .rst, .slot_tick, .cfg_valid, .cfg_ready, .cfg_idx, .cfg_exec,
    .cfg_period, .sched_last, .task_urgent, .task_ahead, .task_contend,
    .task_sym
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_valid[N], m_e[N], m_p[N], m_lag[N], m_ideal[N], m_fid[N];

  function automatic logic [1:0] exp_sym(int i);
    int d;
    if (m_valid[i] == 0) return 2'b00;
    d = m_ideal[i] + m_e[i] - m_fid[i] - m_p[i];
    if (d > 0) return 2'b01;
    if (d == 0) return 2'b00;
    return 2'b11;
  endfunction

  task automatic check_bit(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic check_task(int i, string tag);
    logic [1:0] s;
    logic u, a, c;
    s = exp_sym(i);
    u = (m_valid[i] != 0) && (m_lag[i] > 0) && (s != 2'b11);
    a = (m_valid[i] != 0) && (m_lag[i] < 0) && (s != 2'b01);
    c = (m_valid[i] != 0) && !u && !a;
    checks++;
    if ({task_urgent[i], task_ahead[i], task_contend[i], task_sym[2*i+1 -: 2]} !== {u, a, c, s}) begin
      errors++;
      $display("FAIL %s task %0d got u%0b a%0b c%0b sym %02b expected u%0b a%0b c%0b sym %02b",
               tag, i, task_urgent[i], task_ahead[i], task_contend[i],
               task_sym[2*i+1 -: 2], u, a, c, s);
    end
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < N; i++) check_task(i, tag);
  endtask

  task automatic model_tick(logic [N-1:0] s);
    for (int i = 0; i < N; i++) begin
      if (m_valid[i] != 0) begin
        m_lag[i] += m_e[i] - (s[i] ? m_p[i] : 0);
        if (m_ideal[i] + m_e[i] >= m_fid[i] + m_p[i]) m_fid[i] += m_p[i];
        m_ideal[i] += m_e[i];
      end
    end
  endtask

  task automatic program_entry(int idx, int e, int p);
    @(negedge clk);
    cfg_valid  = 1'b1;
    cfg_idx    = IW'(idx);
    cfg_exec   = PW'(e);
    cfg_period = PW'(p);
    @(negedge clk);
    cfg_valid = 1'b0;
    m_valid[idx] = 1; m_e[idx] = e; m_p[idx] = p;
    m_lag[idx] = 0; m_ideal[idx] = 0; m_fid[idx] = 0;
  endtask

  task automatic do_tick(logic [N-1:0] s);
    @(negedge clk);
    slot_tick  = 1'b1;
    sched_last = s;
    @(negedge clk);
    slot_tick = 1'b0;
    model_tick(s);
  endtask

  // R1: state after reset
  task automatic t_reset_state();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_e[i] = 0; m_p[i] = 0;
      m_lag[i] = 0; m_ideal[i] = 0; m_fid[i] = 0;
    end
    @(negedge clk);
    check_all("R1 reset clears entries");
    check_bit("R1 ready after reset", cfg_ready, 1'b1);
  endtask

  // R2 R8: programming three entries, one left empty
  task automatic t_program_basic();
    program_entry(0, 1, 3);
    program_entry(1, 2, 3);
    program_entry(2, 1, 1);
    check_all("R2 R8 after programming");
    check_bit("R3 task0 minus at start", task_sym[1:0] == 2'b11, 1'b1);
    check_bit("R3 task2 zero at start", task_sym[5:4] == 2'b00, 1'b1);
  endtask

  // R3 R4 R5 R6 R7: hand trace of lag and symbol
  task automatic t_lag_trace();
    do_tick(4'b0010);
    check_all("R4 R5 first strobe");
    check_bit("R3 task1 plus code", task_sym[3:2] == 2'b01, 1'b1);
    check_bit("R6 task2 urgent at weight one", task_urgent[2], 1'b1);
    do_tick(4'b0010);
    check_all("R4 R5 second strobe");
    check_bit("R6 task0 urgent", task_urgent[0], 1'b1);
    check_bit("R7 task1 ahead", task_ahead[1], 1'b1);
    check_bit("R3 task0 zero code", task_sym[1:0] == 2'b00, 1'b1);
    do_tick(4'b0101);
    check_all("R4 served tasks pay a period");
    check_bit("R8 task0 contends after service", task_contend[0], 1'b1);
  endtask

  // R9: service bits move without a strobe
  task automatic t_hold();
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      sched_last = N'(k * 5 + 3);
      @(negedge clk);
      check_all("R9 no strobe no change");
    end
  endtask

  // R2: write offered during the strobe is not taken
  task automatic t_backpressure();
    @(negedge clk);
    slot_tick  = 1'b1;
    sched_last = 4'b0000;
    cfg_valid  = 1'b1;
    cfg_idx    = 2'd3;
    cfg_exec   = 8'd2;
    cfg_period = 8'd7;
    #1;
    check_bit("R2 ready low during strobe", cfg_ready, 1'b0);
    @(negedge clk);
    slot_tick = 1'b0;
    cfg_valid = 1'b0;
    model_tick(4'b0000);
    check_all("R2 write during strobe dropped");
  endtask

  // R11: restart of a single entry
  task automatic t_reprogram();
    program_entry(1, 3, 5);
    check_all("R11 reprogram keeps others");
    do_tick(4'b0001);
    check_all("R11 reprogrammed entry runs fresh");
  endtask

  // R10: every entry follows its own service bit
  task automatic t_parallel();
    logic [7:0] lfsr;
    lfsr = 8'hA5;
    program_entry(3, 2, 7);
    check_all("R10 fourth entry loaded");
    for (int k = 0; k < 40; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      do_tick(lfsr[3:0]);
      check_all("R10 parallel update");
    end
  endtask

  initial begin
    t_reset_state();
    t_program_basic();
    t_lag_trace();
    t_hold();
    t_backpressure();
    t_reprogram();
    t_parallel();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired got running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule